// File: doc/BRIEF.md
# Self-Sizing Call Depth Counter

This block tracks how deeply subroutine calls are nested. It works on a 7-bit depth field that is held elsewhere in the processor status word. The field describes its own counter width. A run of ones, starting at the top bit, marks bits that are not part of the count. The bits below the first zero hold the count value. Because of this, software can pick a small counter, which overflows early and traps at a shallow depth, or a wide one. The value with every bit set turns counting off entirely.

The processor sends a call strobe or a return strobe, together with the current field and the current counting-enable bit. One clock later the block returns the new field, the new enable bit and a one-cycle overflow or underflow flag. Trap handling and the rest of the status word are handled by surrounding logic.

Top module: `call_depth_tracker`

## Requirements
- R1: While reset is asserted, and in the first cycle after reset, depth_o is 0 and cde_o, ovf_o and unf_o are all 0.
- R2: When depth_i is all ones (7'h7F), the field is frozen. A call or return leaves depth_o equal to depth_i and raises neither flag.
- R3: The number of consecutive ones counted down from bit 6, written L, selects the count bits. The count is depth_i masked to its low (7-L) bits.
- R4: All results are registered. On a call with cde_i=1, depth_o becomes depth_i+1 at the next rising edge, provided that the low bits of the sum are not all zero. Those low bits are chosen by the mask that the sum's own leading ones select.
- R5: On a call with cde_i=1, if the low bits of depth_i+1 selected by the sum's own mask are all zero, depth_o keeps depth_i and ovf_o is 1 for that one cycle. For example, 7'h3F and 7'h7E both overflow.
- R6: On a return with cde_i=1, if the masked count of depth_i is nonzero, depth_o becomes depth_i-1.
- R7: On a return with cde_i=1, if the masked count of depth_i is zero, depth_o keeps depth_i and unf_o is 1 for one cycle. ovf_o and unf_o are never 1 together.
- R8: When cde_i=0, a call or return leaves depth_o equal to depth_i and raises no flag.
- R9: After a call, cde_o is 1. In every other cycle, cde_o equals cde_i.
- R10: When call_i and ret_i are both 1, the cycle acts as idle. depth_o equals depth_i, cde_o equals cde_i, and no flag is raised.
- R11: With no strobe, depth_o equals depth_i and both flags are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| call_i | input | 1 | Call strobe (count up) |
| ret_i | input | 1 | Return strobe (count down) |
| cde_i | input | 1 | Current counting-enable bit |
| depth_i | input | 7 | Current depth field |
| depth_o | output | 7 | Updated depth field |
| cde_o | output | 1 | Updated counting-enable bit |
| ovf_o | output | 1 | Overflow pulse |
| unf_o | output | 1 | Underflow pulse |

## Verification
A call does two things in the same cycle: it forces cde_o to one, and it may also overflow the counter. This is most visible when the call arrives with cde_i low, because the count must stay unchanged while the enable bit still rises. The sweep also drives call and return together, which must cancel both the count step and the enable update. Every one of the 128 field values is applied under every combination of enable and strobes. For each vector, the four outputs are compared with a width and mask model that the bench computes by its own loop over the field bits.

// File: rtl/cdt_pkg.sv
package cdt_pkg;

  typedef enum logic [1:0] {
    OP_IDLE   = 2'd0,
    OP_CALL   = 2'd1,
    OP_RET    = 2'd2,
    OP_CANCEL = 2'd3
  } cdt_op_e;

  // Both strobes together cancel each other.
  function automatic cdt_op_e decode_op(input logic call_s, input logic ret_s);
    case ({ret_s, call_s})
      2'b01:   decode_op = OP_CALL;
      2'b10:   decode_op = OP_RET;
      2'b11:   decode_op = OP_CANCEL;
      default: decode_op = OP_IDLE;
    endcase
  endfunction

endpackage

// File: rtl/cdt_lead_ones.sv
// Counts consecutive ones from the top bit downward.
module cdt_lead_ones #(
  parameter int FIELD_W = 7,
  localparam int CNT_W = $clog2(FIELD_W + 1)
) (
  input  logic [FIELD_W-1:0] value_i,
  output logic [CNT_W-1:0]   lead_o
);
  logic [FIELD_W-1:0] prefix;

  assign prefix[FIELD_W-1] = value_i[FIELD_W-1];
  for (genvar i = FIELD_W - 2; i >= 0; i--) begin : g_chain
    assign prefix[i] = prefix[i+1] & value_i[i];
  end

  assign lead_o = CNT_W'($countones(prefix));
endmodule

// File: rtl/cdt_width_mask.sv
// Builds a mask covering the low (FIELD_W - lead) bits.
module cdt_width_mask #(
  parameter int FIELD_W = 7,
  localparam int CNT_W = $clog2(FIELD_W + 1)
) (
  input  logic [CNT_W-1:0]   lead_i,
  output logic [FIELD_W-1:0] mask_o
);
  for (genvar i = 0; i < FIELD_W; i++) begin : g_bit
    assign mask_o[i] = (32'(i) + 32'(lead_i)) < 32'(FIELD_W);
  end
endmodule

// File: rtl/call_depth_tracker.sv
module call_depth_tracker #(
  parameter int FIELD_W = 7,
  localparam int CNT_W = $clog2(FIELD_W + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               call_i,
  input  logic               ret_i,
  input  logic               cde_i,
  input  logic [FIELD_W-1:0] depth_i,
  output logic [FIELD_W-1:0] depth_o,
  output logic               cde_o,
  output logic               ovf_o,
  output logic               unf_o
);
  import cdt_pkg::*;

  localparam logic [FIELD_W-1:0] ALL_ONES = '1;

  cdt_op_e            op;
  logic               frozen;
  logic               counting;
  logic [FIELD_W-1:0] sum_val;
  logic [FIELD_W-1:0] diff_val;
  logic [CNT_W-1:0]   sum_lead;
  logic [CNT_W-1:0]   cur_lead;
  logic [FIELD_W-1:0] sum_mask;
  logic [FIELD_W-1:0] cur_mask;
  logic               step_wrap;
  logic               step_empty;
  logic               ovf_evt;
  logic               unf_evt;
  logic [FIELD_W-1:0] depth_nxt;
  logic               cde_nxt;

  assign op       = decode_op(call_i, ret_i);
  assign frozen   = (depth_i == ALL_ONES);
  assign counting = cde_i && !frozen;
  assign sum_val  = depth_i + FIELD_W'(1);
  assign diff_val = depth_i - FIELD_W'(1);

  // The width for an increment comes from the incremented value itself.
  cdt_lead_ones #(.FIELD_W(FIELD_W)) u_sum_lead (.value_i(sum_val), .lead_o(sum_lead));
  cdt_lead_ones #(.FIELD_W(FIELD_W)) u_cur_lead (.value_i(depth_i), .lead_o(cur_lead));
  cdt_width_mask #(.FIELD_W(FIELD_W)) u_sum_mask (.lead_i(sum_lead), .mask_o(sum_mask));
  cdt_width_mask #(.FIELD_W(FIELD_W)) u_cur_mask (.lead_i(cur_lead), .mask_o(cur_mask));

  assign step_wrap  = ((sum_val & sum_mask) == '0);
  assign step_empty = ((depth_i & cur_mask) == '0);
  assign ovf_evt    = counting && (op == OP_CALL) && step_wrap;
  assign unf_evt    = counting && (op == OP_RET) && step_empty;

  always_comb begin
    depth_nxt = depth_i;
    cde_nxt   = cde_i;
    unique case (op)
      OP_CALL: begin
        cde_nxt = 1'b1;
        if (counting && !step_wrap) depth_nxt = sum_val;
      end
      OP_RET: begin
        if (counting && !step_empty) depth_nxt = diff_val;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      depth_o <= '0;
      cde_o   <= 1'b0;
      ovf_o   <= 1'b0;
      unf_o   <= 1'b0;
    end else begin
      depth_o <= depth_nxt;
      cde_o   <= cde_nxt;
      ovf_o   <= ovf_evt;
      unf_o   <= unf_evt;
    end
  end
endmodule

// File: rtl/cdt_checker.sv
module cdt_checker #(
  parameter int FIELD_W = 7
) (
  input logic               clk,
  input logic               rst_n,
  input logic               call_i,
  input logic               ret_i,
  input logic               cde_i,
  input logic [FIELD_W-1:0] depth_i,
  input logic [FIELD_W-1:0] depth_o,
  input logic               cde_o,
  input logic               ovf_o,
  input logic               unf_o
);
  logic past_ok;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) past_ok <= 1'b0;
    else        past_ok <= 1'b1;
  end

  // R2
  frozen_field_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && ($past(depth_i) == '1)) |-> (depth_o == $past(depth_i) && !ovf_o && !unf_o));

  // R7
  flags_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(ovf_o && unf_o));

  // R5
  overflow_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && ovf_o) |-> (depth_o == $past(depth_i) && $past(call_i) && !$past(ret_i)));

  // R8
  disabled_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && !$past(cde_i)) |-> (depth_o == $past(depth_i) && !ovf_o && !unf_o));

  // R9
  call_sets_cde_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && $past(call_i && !ret_i)) |-> cde_o);

  // R10
  cancel_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && $past(call_i && ret_i)) |->
      (depth_o == $past(depth_i) && cde_o == $past(cde_i) && !ovf_o && !unf_o));
endmodule

bind call_depth_tracker cdt_checker #(.FIELD_W(FIELD_W)) u_cdt_checker (
  .clk(clk), .rst_n(rst_n), .call_i(call_i), .ret_i(ret_i), .cde_i(cde_i),
  .depth_i(depth_i), .depth_o(depth_o), .cde_o(cde_o), .ovf_o(ovf_o), .unf_o(unf_o)
);

// File: tb/call_depth_tracker_bench.sv
module call_depth_tracker_bench;
  localparam int CLK_PERIOD = 10;
  localparam int W = 7;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         call_i = 1'b0;
  logic         ret_i = 1'b0;
  logic         cde_i = 1'b0;
  logic [W-1:0] depth_i = '0;
  logic [W-1:0] depth_o;
  logic         cde_o, ovf_o, unf_o;

  int vectors = 0;
  int misses = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  call_depth_tracker #(.FIELD_W(W)) u_call_depth_tracker (
    .clk(clk), .rst_n(rst_n), .call_i(call_i), .ret_i(ret_i), .cde_i(cde_i),
    .depth_i(depth_i), .depth_o(depth_o), .cde_o(cde_o), .ovf_o(ovf_o), .unf_o(unf_o)
  );

  // R3: count width = W minus the leading ones, found by walking down the bits.
  function automatic int width_of(input int v);
    int lead = 0;
    for (int b = W - 1; b >= 0; b--) begin
      if (((v >> b) & 1) == 0) break;
      lead++;
    end
    return W - lead;
  endfunction

  function automatic int count_of(input int v);
    return v % (1 << width_of(v));
  endfunction

  task automatic check(input string req, input int act, input int exp, input string what);
    vectors++;
    if (act != exp) begin
      misses++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic apply(input int f, input bit en, input bit c, input bit r);
    int exp_f, exp_cde;
    bit exp_ovf, exp_unf;
    string req;
    @(negedge clk);
    depth_i = W'(f); cde_i = en; call_i = c; ret_i = r;
    exp_f = f; exp_ovf = 0; exp_unf = 0; exp_cde = en;
    if (c && r)        req = "R10";
    else if (!c && !r) req = "R11";
    else if (!en)      req = "R8";
    else if (f == 127) req = "R2";
    else if (c) begin
      if (count_of(f + 1) == 0) begin req = "R5"; exp_ovf = 1; end
      else begin req = "R4"; exp_f = f + 1; end
    end else begin
      if (count_of(f) == 0) begin req = "R7"; exp_unf = 1; end
      else begin req = "R6"; exp_f = f - 1; end
    end
    if (c && !r) exp_cde = 1;
    @(negedge clk);
    check(req, int'(depth_o), exp_f, "depth");
    check(req, int'(ovf_o), int'(exp_ovf), "ovf");
    check(req, int'(unf_o), int'(exp_unf), "unf");
    check((c && !r) ? "R9" : req, int'(cde_o), exp_cde, "cde");
  endtask

  initial begin
    depth_i = 7'h55; cde_i = 1'b1; call_i = 1'b1;
    repeat (2) @(negedge clk);
    // R1 reset state
    check("R1", int'(depth_o), 0, "depth");
    check("R1", int'(cde_o), 0, "cde");
    check("R1", int'({ovf_o, unf_o}), 0, "flags");
    @(negedge clk);
    call_i = 1'b0;
    rst_n = 1'b1;
    // Spot checks: 7'h3F and 7'h7E overflow (R5), 7'h40 underflows (R7).
    apply(7'h3F, 1, 1, 0);
    apply(7'h7E, 1, 1, 0);
    apply(7'h40, 1, 0, 1);
    // Full sweep
    for (int f = 0; f < 128; f++)
      for (int e = 0; e < 2; e++)
        for (int s = 0; s < 4; s++)
          apply(f, e[0], s[0], s[1]);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        misses++;
        $display("FAIL watchdog expired actual=running expected=done");
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end
endmodule